// File: doc/BRIEF.md
# Tri-Level Phase-Frequency Detector

This block compares a feedback (sense) pulse train with a reference pulse train and tells a speed or phase control loop which way to push. The only events it responds to are rising edges of the two inputs. Each one moves a ten-state machine one step: a feedback edge moves it up and a reference edge moves it down. The state number sets a three-level output: drive high, drive low, or release the line to a mid level. The mid level is the high-impedance condition. An off-chip resistor network biases it, and that network is outside this block.

When the two frequencies match, the output gives pulses. With feedback leading, it is driven high from each feedback edge until the next reference edge. With feedback lagging, it is driven low from each reference edge until the next feedback edge. At all other times the line is released. A lasting frequency difference drives the machine into a clamped end state, and the output then stays at one level. The two ends are held apart by crossover states, which release the line while the loop moves from correcting frequency to correcting phase. An active-low slip flag marks every state outside the four normal phase-tracking states.

Both inputs are asynchronous to the system clock. Each passes through a synchronizer and a rising-edge detector. The asynchronous reset is released in step with the clock. The drive level is presented as a 2-bit code with a separate output enable, ready for a tri-state pad cell.

Top module: `tristate_phase_detector`

## Requirements
- R1: While reset is active, and once it is released, the machine is in state 5: `pd_code` is 2'b00, `pd_oe` is 0 and `slip_n` is 0. Asserting `rst_n` low forces this condition without waiting for a clock edge.
- R2: Only rising edges of `fb_in` and `ref_in` change the state. A level held for any number of cycles, and any falling edge, leave the state unchanged.
- R3: An input that rises just before clock edge k produces its output update at clock edge k+2. Before that edge the outputs keep their old values.
- R4: A feedback edge alone moves the state as follows: 1→2, 2→7, 3→4, 4→5, 5→2, 6→7, 7→8, 8→9, 9→9, 10→8.
- R5: A reference edge alone moves the state as follows: 1→4, 2→1, 3→3, 4→3, 5→4, 6→1, 7→6, 8→10, 9→8, 10→6.
- R6: `pd_code` is 2'b10 (drive high) in states 7, 8 and 9, 2'b01 (drive low) in states 1, 3 and 4, and 2'b00 (released) in states 2, 5, 6 and 10. `pd_oe` is 1 exactly when `pd_code` is not 2'b00.
- R7: `slip_n` is 1 in states 1, 2, 6 and 7 and is 0 in every other state.
- R8: When rising edges on both inputs are detected in the same clock cycle, the state and all outputs stay as they were.
- R9: With equal input frequencies and a tracking state as the start, each period has one driven pulse whose length in clock cycles equals the separation of the two rising edges. The pulse is high when feedback leads and low when it lags. The line is released for the rest of the period.
- R10: A feedback frequency above the reference frequency saturates the output high and holds it there: the state settles in {8, 9} and is clamped at 9. A reference frequency above the feedback frequency saturates it low: the state settles in {3, 4} and is clamped at 3. In both cases `slip_n` is 0.
- R11: When the loop leaves positive saturation, the machine passes through crossover state 10 before it reaches a tracking state. In state 10 the line is released and `slip_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all sampling and state updates use its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with the clock inside the block |
| fb_in | input | 1 | Feedback (sense) pulse train, asynchronous to clk |
| ref_in | input | 1 | Reference pulse train, asynchronous to clk |
| pd_code | output | 2 | Drive code: 2'b10 high, 2'b01 low, 2'b00 released |
| pd_oe | output | 1 | Output enable for the pad; 1 when the line is driven |
| slip_n | output | 1 | Active-low flag; 0 outside the tracking states 1, 2, 6, 7 |

## Verification
An input edge passes through two synchronizer flops and is then registered into the state. Each result therefore appears on the third rising clock edge, counting the edge that first samples the input high. One directed test stops at the falling edge before that clock edge and again at the falling edge after it, to fix that exact cycle. Every other check holds its stimulus for three cycles, waits at least five more, and samples at a falling clock edge, so the outputs have settled by the time they are read. The pulse-width and saturation checks count, once per cycle, the falling-edge samples of outputs that are delayed by the same three cycles on both inputs. A driven pulse therefore lasts exactly as many cycles as the gap between the two input edges.

// File: rtl/tpd_pkg.sv
package tpd_pkg;

  localparam int unsigned TPD_NUM_IN  = 2;
  localparam int unsigned TPD_IDX_FB  = 0;
  localparam int unsigned TPD_IDX_REF = 1;

  // State numbers are behavioural: they fix the drive level and the slip flag
  typedef enum logic [3:0] {
    TPD_S1  = 4'd1,
    TPD_S2  = 4'd2,
    TPD_S3  = 4'd3,
    TPD_S4  = 4'd4,
    TPD_S5  = 4'd5,
    TPD_S6  = 4'd6,
    TPD_S7  = 4'd7,
    TPD_S8  = 4'd8,
    TPD_S9  = 4'd9,
    TPD_S10 = 4'd10
  } tpd_state_e;

  typedef enum logic [1:0] {
    TPD_REL  = 2'b00,
    TPD_LOW  = 2'b01,
    TPD_HIGH = 2'b10
  } tpd_drive_e;

  // Step taken on a lone feedback edge
  function automatic tpd_state_e tpd_fb_step(input tpd_state_e s);
    case (s)
      TPD_S1:  return TPD_S2;
      TPD_S2:  return TPD_S7;
      TPD_S3:  return TPD_S4;
      TPD_S4:  return TPD_S5;
      TPD_S5:  return TPD_S2;
      TPD_S6:  return TPD_S7;
      TPD_S7:  return TPD_S8;
      TPD_S8:  return TPD_S9;
      TPD_S9:  return TPD_S9;
      TPD_S10: return TPD_S8;
      default: return TPD_S5;
    endcase
  endfunction

  // Step taken on a lone reference edge
  function automatic tpd_state_e tpd_ref_step(input tpd_state_e s);
    case (s)
      TPD_S1:  return TPD_S4;
      TPD_S2:  return TPD_S1;
      TPD_S3:  return TPD_S3;
      TPD_S4:  return TPD_S3;
      TPD_S5:  return TPD_S4;
      TPD_S6:  return TPD_S1;
      TPD_S7:  return TPD_S6;
      TPD_S8:  return TPD_S10;
      TPD_S9:  return TPD_S8;
      TPD_S10: return TPD_S6;
      default: return TPD_S5;
    endcase
  endfunction

  function automatic tpd_drive_e tpd_drive_of(input tpd_state_e s);
    case (s)
      TPD_S7, TPD_S8, TPD_S9: return TPD_HIGH;
      TPD_S1, TPD_S3, TPD_S4: return TPD_LOW;
      default:                return TPD_REL;
    endcase
  endfunction

  function automatic logic tpd_tracking(input tpd_state_e s);
    return (s == TPD_S1) || (s == TPD_S2) || (s == TPD_S6) || (s == TPD_S7);
  endfunction

endpackage

// File: rtl/tpd_reset_sync.sv
module tpd_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/tpd_edge_sync.sv
module tpd_edge_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);

  localparam int unsigned MSB = SYNC_STAGES - 1;

  logic [MSB:0] sync_q;
  logic         last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[MSB-1:0], din};
      last_q <= sync_q[MSB];
    end
  end

  assign rise = sync_q[MSB] & ~last_q;

  // R2: a held level yields a single-cycle event, never two in a row
  assert_single_pulse_R2: assert property (
    @(posedge clk) disable iff (!rst_n)
    rise |=> !rise
  );

endmodule

// File: rtl/tpd_state_ring.sv
module tpd_state_ring
  import tpd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fb_rise,
  input  logic       ref_rise,
  output logic [1:0] pd_code,
  output logic       pd_oe,
  output logic       slip_n
);

  tpd_state_e state_q, state_d;
  tpd_drive_e drive_q, drive_d;
  logic       oe_q, oe_d;
  logic       slip_n_q, slip_n_d;
  logic       step_en;

  // Next-state and output decode
  always_comb begin
    step_en = fb_rise ^ ref_rise;
    state_d = state_q;
    if (fb_rise && !ref_rise) begin
      state_d = tpd_fb_step(state_q);
    end else if (ref_rise && !fb_rise) begin
      state_d = tpd_ref_step(state_q);
    end
    drive_d  = tpd_drive_of(state_d);
    oe_d     = (drive_d != TPD_REL);
    slip_n_d = tpd_tracking(state_d);
  end

  // Registers, updated only when exactly one input edge is present
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= TPD_S5;
      drive_q  <= TPD_REL;
      oe_q     <= 1'b0;
      slip_n_q <= 1'b0;
    end else if (step_en) begin
      state_q  <= state_d;
      drive_q  <= drive_d;
      oe_q     <= oe_d;
      slip_n_q <= slip_n_d;
    end
  end

  assign pd_code = drive_q;
  assign pd_oe   = oe_q;
  assign slip_n  = slip_n_q;

  // R8: coincident edges, or none, leave the state alone
  assert_coincident_hold_R8: assert property (
    @(posedge clk) disable iff (!rst_n)
    (fb_rise == ref_rise) |=> $stable(state_q)
  );

  // R2: any state change is caused by a detected edge one cycle earlier
  assert_change_needs_edge_R2: assert property (
    @(posedge clk) disable iff (!rst_n)
    !$stable(state_q) |-> $past(fb_rise || ref_rise)
  );

  // R10: the upper end of the ladder is clamped
  assert_clamp_top_R10: assert property (
    @(posedge clk) disable iff (!rst_n)
    (state_q == TPD_S9 && fb_rise && !ref_rise) |=> (state_q == TPD_S9)
  );

  // R10: the lower end of the ladder is clamped
  assert_clamp_bottom_R10: assert property (
    @(posedge clk) disable iff (!rst_n)
    (state_q == TPD_S3 && ref_rise && !fb_rise) |=> (state_q == TPD_S3)
  );

  // R11: leaving positive saturation goes through the crossover state
  assert_crossover_path_R11: assert property (
    @(posedge clk) disable iff (!rst_n)
    (state_q == TPD_S8 && ref_rise && !fb_rise) |=> (state_q == TPD_S10)
  );

endmodule

// File: rtl/tristate_phase_detector.sv
module tristate_phase_detector
  import tpd_pkg::*;
#(
  parameter int unsigned SYNC_STAGES  = 2,
  parameter int unsigned RESET_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fb_in,
  input  logic       ref_in,
  output logic [1:0] pd_code,
  output logic       pd_oe,
  output logic       slip_n
);

  logic                  rst_core_n;
  logic [TPD_NUM_IN-1:0] raw_in;
  logic [TPD_NUM_IN-1:0] rise_vec;

  assign raw_in[TPD_IDX_FB]  = fb_in;
  assign raw_in[TPD_IDX_REF] = ref_in;

  tpd_reset_sync #(
    .STAGES (RESET_STAGES)
  ) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  for (genvar gi = 0; gi < TPD_NUM_IN; gi++) begin : g_in
    tpd_edge_sync #(
      .SYNC_STAGES (SYNC_STAGES)
    ) u_edge (
      .clk   (clk),
      .rst_n (rst_core_n),
      .din   (raw_in[gi]),
      .rise  (rise_vec[gi])
    );
  end

  tpd_state_ring u_ring (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .fb_rise  (rise_vec[TPD_IDX_FB]),
    .ref_rise (rise_vec[TPD_IDX_REF]),
    .pd_code  (pd_code),
    .pd_oe    (pd_oe),
    .slip_n   (slip_n)
  );

endmodule

// File: tb/tristate_phase_detector_test.sv
module tristate_phase_detector_test;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 26;

  // Each entry: {event[1:0] (01 feedback, 10 reference, 11 both), code[1:0], slip_n}
  localparam logic [4:0] VEC [0:NVEC-1] = '{
    5'b01_00_1, 5'b01_10_1, 5'b10_00_1, 5'b10_01_1, 5'b01_00_1,
    5'b10_01_1, 5'b10_01_0, 5'b10_01_0, 5'b10_01_0, 5'b01_01_0,
    5'b01_00_0, 5'b10_01_0, 5'b01_00_0, 5'b01_00_1, 5'b01_10_1,
    5'b11_10_1, 5'b01_10_0, 5'b01_10_0, 5'b01_10_0, 5'b10_10_0,
    5'b10_00_0, 5'b01_10_0, 5'b10_00_0, 5'b10_00_1, 5'b01_10_1,
    5'b10_00_1
  };

  logic       clk;
  logic       rst_n;
  logic       fb_in;
  logic       ref_in;
  logic [1:0] pd_code;
  logic       pd_oe;
  logic       slip_n;

  int checks;
  int errors;

  tristate_phase_detector uut (
    .clk     (clk),
    .rst_n   (rst_n),
    .fb_in   (fb_in),
    .ref_in  (ref_in),
    .pd_code (pd_code),
    .pd_oe   (pd_oe),
    .slip_n  (slip_n)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_out(input logic [1:0] exp_code, input logic exp_slip, input string req);
    check(pd_code == exp_code, {req, " pd_code"}, int'(pd_code), int'(exp_code));
    check(pd_oe == (exp_code != 2'b00), {req, " pd_oe"}, int'(pd_oe), int'(exp_code != 2'b00));
    check(slip_n == exp_slip, {req, " slip_n"}, int'(slip_n), int'(exp_slip));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n  = 1'b0;
    fb_in  = 1'b0;
    ref_in = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic apply_event(input logic [1:0] ev);
    @(negedge clk);
    fb_in  = ev[0];
    ref_in = ev[1];
    repeat (3) @(negedge clk);
    fb_in  = 1'b0;
    ref_in = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  // Periodic stimulus: pulses 5 cycles wide; no new pulse starts at or after 'stop'.
  // Counts samples taken at or after 'win' by drive level, plus released-and-slipping samples overall.
  task automatic run_wave(input int fb_per, input int fb_off, input int ref_per, input int ref_off,
                          input int cycles, input int stop, input int win,
                          output int n_high, output int n_low, output int n_xover);
    n_high  = 0;
    n_low   = 0;
    n_xover = 0;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      if (c >= win) begin
        if (pd_code == 2'b10) n_high++;
        if (pd_code == 2'b01) n_low++;
      end
      if (pd_code == 2'b00 && !slip_n) n_xover++;
      fb_in  = (c < stop) && (c >= fb_off) && (((c - fb_off) % fb_per) < 5);
      ref_in = (c < stop) && (c >= ref_off) && (((c - ref_off) % ref_per) < 5);
    end
    fb_in  = 1'b0;
    ref_in = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1 actual=%0d expected=%0d", 200000, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int nh, nl, nx;
    checks = 0;
    errors = 0;
    rst_n  = 1'b0;
    fb_in  = 1'b0;
    ref_in = 1'b0;

    // R1: reset state
    do_reset();
    check_out(2'b00, 1'b0, "R1 after reset");

    // Vector table walk: every lone-edge step of R4 and R5, decode R6, flag R7,
    // coincident edges R8, clamps R10, crossover state 10 R11
    for (int i = 0; i < NVEC; i++) begin
      apply_event(VEC[i][4:3]);
      check_out(VEC[i][2:1], VEC[i][0], $sformatf("R4 R5 R6 R7 R8 R10 R11 vector %0d", i));
    end

    // R3: exact latency from state 5 to state 2 (slip_n rises)
    do_reset();
    @(negedge clk);
    fb_in = 1'b1;
    @(negedge clk);
    check(slip_n == 1'b0, "R3 one edge after input", int'(slip_n), 0);
    @(negedge clk);
    check(slip_n == 1'b0, "R3 two edges after input", int'(slip_n), 0);
    @(negedge clk);
    check(slip_n == 1'b1, "R3 three edges after input", int'(slip_n), 1);

    // R2: level held high and then dropped causes no further step (still state 2)
    repeat (20) @(negedge clk);
    check_out(2'b00, 1'b1, "R2 feedback level held");
    fb_in = 1'b0;
    repeat (10) @(negedge clk);
    check_out(2'b00, 1'b1, "R2 feedback falling edge");
    ref_in = 1'b1;
    repeat (25) @(negedge clk);
    check_out(2'b01, 1'b1, "R2 reference level held (state 1, not 4)");
    ref_in = 1'b0;
    repeat (10) @(negedge clk);
    check_out(2'b01, 1'b1, "R2 reference falling edge");
    apply_event(2'b01);
    check_out(2'b00, 1'b1, "R2 R4 back to state 2");

    // R9: equal frequency, feedback leads by 10 cycles, four periods from state 2
    run_wave(40, 0, 40, 10, 170, 160, 0, nh, nl, nx);
    check(nh == 40, "R9 lead high cycles", nh, 40);
    check(nl == 0, "R9 lead low cycles", nl, 0);
    check_out(2'b00, 1'b1, "R9 lead ends in state 6");

    // R9: equal frequency, feedback lags by 12 cycles, four periods from state 6
    run_wave(40, 12, 40, 0, 170, 160, 0, nh, nl, nx);
    check(nl == 48, "R9 lag low cycles", nl, 48);
    check(nh == 0, "R9 lag high cycles", nh, 0);
    check_out(2'b00, 1'b1, "R9 lag ends in state 2");

    // R10: faster feedback saturates high
    do_reset();
    run_wave(20, 0, 30, 5, 600, 600, 400, nh, nl, nx);
    check(nh == 200, "R10 fast feedback high cycles", nh, 200);
    check(slip_n == 1'b0, "R10 fast feedback slip_n", int'(slip_n), 0);
    check(pd_code == 2'b10, "R10 fast feedback final level", int'(pd_code), 2);

    // R11 then R10 mirror: faster reference from positive saturation
    run_wave(30, 5, 20, 0, 600, 600, 400, nh, nl, nx);
    check(nx > 0, "R11 crossover released cycles seen", nx, 1);
    check(nl == 200, "R10 fast reference low cycles", nl, 200);
    check(slip_n == 1'b0, "R10 fast reference slip_n", int'(slip_n), 0);

    // R1: asynchronous reset while driving low
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check_out(2'b00, 1'b0, "R1 asynchronous reset");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check_out(2'b00, 1'b0, "R1 after release");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule